// File: doc/BRIEF.md
# Segment and I/O Privilege Checker

This unit takes one protection query at a time and answers whether it is allowed or must raise a general protection fault. A query carries the current privilege level, the privilege level requested by the selector, the privilege level of the target descriptor, a real-mode flag, the I/O privilege field, an operation class, a port number and a flag saying whether the running task state segment is the 32-bit kind. Privilege levels are 2-bit numbers where 0 is the most trusted and 3 the least.

Most answers are formed combinationally and registered, so they appear as a one-cycle result pulse on the cycle after the query is taken. One case cannot be settled locally. A port I/O instruction from a level above the I/O privilege field, inside a 32-bit task state segment, needs one bit from a per-port permission bitmap. For that case the unit sends the port number to an external bitmap agent over a valid/ready channel and waits for the one-bit reply. While it waits it refuses new queries.

The sequencer has three states. ST_IDLE accepts queries. It moves to ST_ISSUE when a bitmap lookup is needed and otherwise stays in ST_IDLE. ST_ISSUE holds the lookup request until the agent accepts it, then moves to ST_WAIT. ST_WAIT waits for the reply pulse, then returns to ST_IDLE.

Top module: `segio_priv_check`

## Requirements
- R1: After reset `rsp_valid` and `map_req_valid` are 0 and `req_ready` is 1.
- R2: The effective level is the larger of `req_rpl` and the current level. A memory query (`req_op` = 0) has `rsp_fault` = 1 exactly when the effective level exceeds `req_dpl`. `rsp_valid` is high in the cycle after the query is accepted (`req_valid` and `req_ready` both high at a clock edge).
- R3: When `req_real` is 1 the current level is treated as 0 for every operation class, whatever `req_cpl` holds.
- R4: For port I/O (`req_op` = 1) and other I/O-sensitive operations (`req_op` = 2), a current level at or below `req_iopl` passes (`rsp_fault` = 0) in the cycle after acceptance, and no lookup is issued.
- R5: When the current level is above `req_iopl` and `req_tss32` = 0, operation classes 1 and 2 fault in the cycle after acceptance.
- R6: When the current level is above `req_iopl` and `req_tss32` = 1, class 2 faults in the cycle after acceptance without a lookup.
- R7: When the current level is above `req_iopl`, `req_tss32` = 1 and class is 1, `map_req_valid` rises in the cycle after acceptance. `map_port` equals `req_port` and stays stable until `map_req_ready` is taken. `req_ready` stays 0 from acceptance until the result is delivered.
- R8: The reply taken with `map_rsp_valid` yields `rsp_valid` = 1 in the next cycle, with `rsp_fault` equal to `map_rsp_bit`: bit 0 allows the port and bit 1 faults.
- R9: The reserved class `req_op` = 3 always faults in the cycle after acceptance.
- R10: `req_valid` has no effect while `req_ready` is 0: no result and no further lookup follows from it.
- R11: `rsp_valid` is a single-cycle pulse per accepted query. With no new acceptance or reply, it is 0 in the cycle after a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Query present |
| req_ready | output | 1 | Unit can take a query |
| req_cpl | input | 2 | Current privilege level |
| req_rpl | input | 2 | Selector requested level |
| req_dpl | input | 2 | Descriptor privilege level |
| req_real | input | 1 | Real mode (current level forced to 0) |
| req_iopl | input | 2 | I/O privilege field |
| req_op | input | 2 | 0 memory, 1 port I/O, 2 other I/O-sensitive, 3 reserved |
| req_port | input | PORT_W | Port number for class 1 |
| req_tss32 | input | 1 | Task state segment is 32-bit |
| map_req_valid | output | 1 | Bitmap lookup request |
| map_req_ready | input | 1 | Agent accepts lookup |
| map_port | output | PORT_W | Port being looked up |
| map_rsp_valid | input | 1 | Lookup reply present |
| map_rsp_bit | input | 1 | Permission bit (1 = deny) |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | 1 = general protection fault |

## Verification
The bench builds the unit with its default 16-bit port width. The privilege inputs span 4096 combinations: every current, requested and descriptor level, both mode flags, every I/O privilege value and every operation class. Each combination is applied once, so all fault boundaries between effective level and descriptor level, and between current level and I/O privilege, are visited. The lookup path is run with varied agent accept and reply delays, with port-dependent permission bits of both values, and with stray queries driven while the unit is busy.

// File: rtl/priv_chk_pkg.sv
package priv_chk_pkg;

    typedef enum logic [1:0] {
        OP_MEM  = 2'd0,
        OP_PORT = 2'd1,
        OP_SENS = 2'd2,
        OP_RSV  = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        V_PASS   = 2'd0,
        V_FAULT  = 2'd1,
        V_LOOKUP = 2'd2
    } verdict_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/priv_eff_level.sv
module priv_eff_level #(
    parameter int LVL_W = 2
) (
    input  logic [LVL_W-1:0] cpl_in,
    input  logic             real_mode,
    input  logic [LVL_W-1:0] rpl_in,
    output logic [LVL_W-1:0] cpl_eff,
    output logic [LVL_W-1:0] epl
);
    // Real mode runs at the most trusted level.
    always_comb begin
        cpl_eff = real_mode ? '0 : cpl_in;
        epl     = (rpl_in > cpl_eff) ? rpl_in : cpl_eff;
    end
endmodule

// File: rtl/priv_rule_eval.sv
module priv_rule_eval
    import priv_chk_pkg::*;
#(
    parameter int LVL_W = 2
) (
    input  op_class_e        op,
    input  logic [LVL_W-1:0] cpl_eff,
    input  logic [LVL_W-1:0] epl,
    input  logic [LVL_W-1:0] dpl,
    input  logic [LVL_W-1:0] iopl,
    input  logic             tss32,
    output verdict_e         verdict
);
    logic io_trusted;

    always_comb begin
        io_trusted = (cpl_eff <= iopl);
        verdict    = V_FAULT;
        unique case (op)
            OP_MEM:  verdict = (epl <= dpl) ? V_PASS : V_FAULT;
            OP_PORT: begin
                if (io_trusted)      verdict = V_PASS;
                else if (tss32)      verdict = V_LOOKUP;
                else                 verdict = V_FAULT;
            end
            OP_SENS: verdict = io_trusted ? V_PASS : V_FAULT;
            OP_RSV:  verdict = V_FAULT;
            default: verdict = V_FAULT;
        endcase
    end
endmodule

// File: rtl/priv_seq_fsm.sv
module priv_seq_fsm
    import priv_chk_pkg::*;
#(
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  verdict_e          verdict,
    input  logic [PORT_W-1:0] req_port,
    output logic              map_req_valid,
    input  logic              map_req_ready,
    output logic [PORT_W-1:0] map_port,
    input  logic              map_rsp_valid,
    input  logic              map_rsp_bit,
    output logic              rsp_valid,
    output logic              rsp_fault
);
    seq_state_e state_q, state_d;
    logic       take;

    assign take = req_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take && verdict == V_LOOKUP) state_d = ST_ISSUE;
            ST_ISSUE: if (map_req_ready)               state_d = ST_WAIT;
            ST_WAIT:  if (map_rsp_valid)               state_d = ST_IDLE;
            default:                                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            map_port  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        if (verdict == V_LOOKUP) begin
                            map_port <= req_port;
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_fault <= (verdict != V_PASS);
                        end
                    end
                end
                ST_ISSUE: ;
                ST_WAIT: begin
                    if (map_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_fault <= map_rsp_bit;
                    end
                end
                default: ;
            endcase
        end
    end

    assign req_ready     = (state_q == ST_IDLE);
    assign map_req_valid = (state_q == ST_ISSUE);
endmodule

// File: rtl/segio_priv_check.sv
module segio_priv_check
    import priv_chk_pkg::*;
#(
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_cpl,
    input  logic [1:0]        req_rpl,
    input  logic [1:0]        req_dpl,
    input  logic              req_real,
    input  logic [1:0]        req_iopl,
    input  logic [1:0]        req_op,
    input  logic [PORT_W-1:0] req_port,
    input  logic              req_tss32,
    output logic              map_req_valid,
    input  logic              map_req_ready,
    output logic [PORT_W-1:0] map_port,
    input  logic              map_rsp_valid,
    input  logic              map_rsp_bit,
    output logic              rsp_valid,
    output logic              rsp_fault
);
    localparam int LVL_W = 2;

    logic [LVL_W-1:0] cpl_eff, epl;
    verdict_e         verdict;
    op_class_e        op_cls;

    assign op_cls = op_class_e'(req_op);

    priv_eff_level #(.LVL_W(LVL_W)) u_lvl (
        .cpl_in    (req_cpl),
        .real_mode (req_real),
        .rpl_in    (req_rpl),
        .cpl_eff   (cpl_eff),
        .epl       (epl)
    );

    priv_rule_eval #(.LVL_W(LVL_W)) u_rule (
        .op      (op_cls),
        .cpl_eff (cpl_eff),
        .epl     (epl),
        .dpl     (req_dpl),
        .iopl    (req_iopl),
        .tss32   (req_tss32),
        .verdict (verdict)
    );

    priv_seq_fsm #(.PORT_W(PORT_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .verdict       (verdict),
        .req_port      (req_port),
        .map_req_valid (map_req_valid),
        .map_req_ready (map_req_ready),
        .map_port      (map_port),
        .map_rsp_valid (map_rsp_valid),
        .map_rsp_bit   (map_rsp_bit),
        .rsp_valid     (rsp_valid),
        .rsp_fault     (rsp_fault)
    );
endmodule

// File: rtl/segio_priv_check_props.sv
module segio_priv_check_props #(
    parameter int PORT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_cpl,
    input logic [1:0]        req_rpl,
    input logic [1:0]        req_dpl,
    input logic              req_real,
    input logic [1:0]        req_iopl,
    input logic [1:0]        req_op,
    input logic              req_tss32,
    input logic              map_req_valid,
    input logic              map_req_ready,
    input logic [PORT_W-1:0] map_port,
    input logic              map_rsp_valid,
    input logic              map_rsp_bit,
    input logic              rsp_valid,
    input logic              rsp_fault
);
    logic       acc;
    logic [1:0] ce, el;
    assign acc = req_valid && req_ready;
    assign ce  = req_real ? 2'd0 : req_cpl;
    assign el  = (req_rpl > ce) ? req_rpl : ce;

    AST_MEM_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_op == 2'd0 |=> rsp_valid && (rsp_fault == $past(el > req_dpl))); // R2
    AST_IO_TRUSTED: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (req_op == 2'd1 || req_op == 2'd2) && ce <= req_iopl |=> rsp_valid && !rsp_fault && !map_req_valid); // R4
    AST_IO_TSS16: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (req_op == 2'd1 || req_op == 2'd2) && ce > req_iopl && !req_tss32 |=> rsp_valid && rsp_fault); // R5
    AST_SENS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_op == 2'd2 && ce > req_iopl |=> rsp_valid && rsp_fault && !map_req_valid); // R6
    AST_LOOKUP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        map_req_valid |-> !req_ready); // R7
    AST_PORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        map_req_valid && !map_req_ready |=> map_req_valid && $stable(map_port)); // R7
    AST_REPLY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        map_rsp_valid && !req_ready && !map_req_valid |=> rsp_valid && (rsp_fault == $past(map_rsp_bit))); // R8
    AST_RSV_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_op == 2'd3 |=> rsp_valid && rsp_fault); // R9
    AST_RSP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(acc) || $past(map_rsp_valid)); // R11
endmodule

bind segio_priv_check segio_priv_check_props #(.PORT_W(PORT_W)) u_props (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_cpl       (req_cpl),
    .req_rpl       (req_rpl),
    .req_dpl       (req_dpl),
    .req_real      (req_real),
    .req_iopl      (req_iopl),
    .req_op        (req_op),
    .req_tss32     (req_tss32),
    .map_req_valid (map_req_valid),
    .map_req_ready (map_req_ready),
    .map_port      (map_port),
    .map_rsp_valid (map_rsp_valid),
    .map_rsp_bit   (map_rsp_bit),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault)
);

// File: tb/segio_priv_check_test.sv
`timescale 1ns/1ps
module segio_priv_check_test;
    localparam int PORT_W = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n, req_valid, req_ready, req_real, req_tss32;
    logic [1:0]        req_cpl, req_rpl, req_dpl, req_iopl, req_op;
    logic [PORT_W-1:0] req_port, map_port;
    logic              map_req_valid, map_req_ready, map_rsp_valid, map_rsp_bit;
    logic              rsp_valid, rsp_fault;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    segio_priv_check #(.PORT_W(PORT_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cpl(req_cpl), .req_rpl(req_rpl), .req_dpl(req_dpl), .req_real(req_real),
        .req_iopl(req_iopl), .req_op(req_op), .req_port(req_port), .req_tss32(req_tss32),
        .map_req_valid(map_req_valid), .map_req_ready(map_req_ready), .map_port(map_port),
        .map_rsp_valid(map_rsp_valid), .map_rsp_bit(map_rsp_bit),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_one(input int idx);
        logic [1:0] cpl, rpl, dpl, iopl, op, ce, el;
        logic       rl, t32, fault, lookup, bitv;
        logic [PORT_W-1:0] port;
        cpl  = idx[1:0];
        rpl  = idx[3:2];
        dpl  = idx[5:4];
        iopl = idx[7:6];
        op   = idx[9:8];
        rl   = idx[10];
        t32  = idx[11];
        port = PORT_W'(idx * 37) ^ 16'hA5C3;
        ce   = rl ? 2'd0 : cpl;
        el   = (rpl > ce) ? rpl : ce;
        lookup = 1'b0;
        fault  = 1'b1;
        case (op)
            2'd0: fault = (el > dpl);
            2'd1: if (ce <= iopl) fault = 1'b0; else if (t32) lookup = 1'b1;
            2'd2: fault = (ce > iopl);
            default: fault = 1'b1;
        endcase

        @(negedge clk);
        req_valid = 1'b1; req_cpl = cpl; req_rpl = rpl; req_dpl = dpl;
        req_iopl = iopl; req_op = op; req_real = rl; req_tss32 = t32; req_port = port;
        @(negedge clk);
        req_valid = 1'b0;
        if (!lookup) begin
            chk(op == 2'd0 ? "R2 mem verdict" : (op == 2'd3 ? "R9 reserved" :
                (ce <= iopl ? "R4 io trusted" : (t32 ? "R6 sensitive fault" : "R5 tss16 fault"))),
                {30'd0, rsp_valid, rsp_fault}, {30'd0, 1'b1, fault});
            if (rl && cpl != 2'd0) chk("R3 real mode level", {31'd0, rsp_fault}, {31'd0, fault});
            chk("R4 no lookup", {31'd0, map_req_valid}, 32'd0);
            @(negedge clk);
            chk("R11 pulse", {31'd0, rsp_valid}, 32'd0);
        end else begin
            bitv = ^port;
            chk("R7 lookup issued", {30'd0, map_req_valid, req_ready}, 32'd2);
            chk("R7 lookup port", {16'd0, map_port}, {16'd0, port});
            chk("R7 no early result", {31'd0, rsp_valid}, 32'd0);
            for (int d = 0; d < idx % 3; d++) begin
                req_valid = 1'b1; req_op = 2'd0; req_rpl = 2'd0; req_cpl = 2'd0;
                req_real = 1'b0; req_port = ~port;
                @(negedge clk);
                chk("R10 busy ignore", {29'd0, rsp_valid, map_req_valid, req_ready}, 32'd2);
                chk("R7 port stable", {16'd0, map_port}, {16'd0, port});
            end
            req_valid = 1'b0;
            map_req_ready = 1'b1;
            @(negedge clk);
            map_req_ready = 1'b0;
            chk("R7 request dropped", {30'd0, map_req_valid, req_ready}, 32'd0);
            for (int d = 0; d < idx % 2; d++) @(negedge clk);
            map_rsp_valid = 1'b1; map_rsp_bit = bitv;
            @(negedge clk);
            map_rsp_valid = 1'b0; map_rsp_bit = 1'b0;
            chk("R8 reply result", {29'd0, rsp_valid, rsp_fault, req_ready}, {29'd0, 1'b1, bitv, 1'b1});
            @(negedge clk);
            chk("R11 pulse after reply", {30'd0, rsp_valid, map_req_valid}, 32'd0);
        end
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_cpl = '0; req_rpl = '0; req_dpl = '0;
        req_real = 1'b0; req_iopl = '0; req_op = '0; req_port = '0; req_tss32 = 1'b0;
        map_req_ready = 1'b0; map_rsp_valid = 1'b0; map_rsp_bit = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state", {29'd0, rsp_valid, map_req_valid, req_ready}, 32'd1);
        for (int i = 0; i < 4096; i++) run_one(i);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule